// File: doc/BRIEF.md
# Parallel-Load Shift Register with Hold

An eight-stage register that, on each rising clock edge, does one of two things. It either captures a parallel word into all stages at once, or it moves its contents one stage toward the output end and takes a new serial bit into the first stage. A mode input chooses between the two on every edge. A separate hold input freezes the register completely, whichever mode is selected. The serial output is the last stage. The full stage vector is also brought out so that a host or a debugger can see it.

The block is typically used to turn a parallel word into a serial stream: load a word, then shift it out one bit per edge. It can also be used to collect serial bits. An active-low clear takes effect at once, without waiting for a clock edge. The clear is released on the clock: two internal synchronizer stages delay its removal, so the register leaves the cleared state in step with the clock.

Top module: `plsr_shift_reg`

## Requirements
- R1: The register has `WIDTH` stages, 8 by default, numbered 0 (first) to `WIDTH-1` (last). `sout` always equals the value of stage `WIDTH-1`.
- R2: On a rising edge with `hold_en`=0 and `mode_shift`=0, every stage i takes `pdata[i]` at the same moment.
- R3: On a rising edge with `hold_en`=0 and `mode_shift`=1, stage 0 takes `sin` and every stage i>0 takes the old value of stage i-1.
- R4: On a rising edge with `hold_en`=1, no stage changes, whatever the values of `mode_shift`, `sin` and `pdata`.
- R5: When `rst_n` goes low, every stage becomes 0 at once, without a clock edge. While `rst_n` is low, the stages stay 0 and all other inputs are ignored.
- R6: After `rst_n` rises, the stages stay 0 through the first two rising edges, even if those edges request a load or a shift. The third rising edge is the first one that acts.
- R7: After a load, successive shifts present on `sout` the bits `pdata[WIDTH-1]`, `pdata[WIDTH-2]`, and so on down to `pdata[0]`. After those, `sout` gives the serial bits in the order they were applied.
- R8: `state_q[i]` is the value of stage i, so it reflects every load, shift, hold and clear as it happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register acts on the rising edge |
| rst_n | input | 1 | Active-low clear; takes effect at once and is released on the clock |
| mode_shift | input | 1 | 1 = shift toward the last stage, 0 = parallel load |
| hold_en | input | 1 | 1 = freeze the contents on every edge |
| sin | input | 1 | Serial bit entering stage 0 when shifting |
| pdata | input | WIDTH | Parallel word; bit i goes to stage i |
| sout | output | 1 | Last stage |
| state_q | output | WIDTH | All stages, bit i = stage i |

## Verification
The hardest case to reach is the window just after the clear is released. In that window the input pins say "load" or "shift", yet the register must still read zero for exactly two edges. The bench holds a load request with a non-zero word steady across the release, so any early or late exit from the cleared state is visible on `state_q`. A second hard case is a clear that arrives between two clock edges while the register is busy. The bench drops `rst_n` in the middle of the low clock phase and samples the outputs before the next edge. Everything else is covered by a reference model written with plain integer shifting, driven by a pseudo-random mix of mode and hold values and compared with the design on every cycle.

// File: rtl/plsr_pkg.sv
package plsr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } plsr_op_e;

  // hold has priority over both transfer modes
  function automatic plsr_op_e pick_op(input logic hold, input logic shift);
    if (hold)       return OP_HOLD;
    else if (shift) return OP_SHIFT;
    else            return OP_LOAD;
  endfunction

endpackage

// File: rtl/plsr_rst_sync.sv
module plsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/plsr_ctrl.sv
module plsr_ctrl
  import plsr_pkg::*;
(
  input  logic hold_en,
  input  logic mode_shift,
  output logic clk_en,
  output logic sel_shift,
  output logic sel_load
);
  plsr_op_e op;

  always_comb begin
    op        = pick_op(hold_en, mode_shift);
    clk_en    = 1'b0;
    sel_shift = 1'b0;
    sel_load  = 1'b0;
    unique case (op)
      OP_LOAD:  begin clk_en = 1'b1; sel_load  = 1'b1; end
      OP_SHIFT: begin clk_en = 1'b1; sel_shift = 1'b1; end
      default:  begin clk_en = 1'b0; end
    endcase
  end
endmodule

// File: rtl/plsr_cell.sv
module plsr_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic sel_shift,
  input  logic sel_load,
  input  logic d_ser,
  input  logic d_par,
  output logic q
);
  logic q_r;
  logic q_nxt;

  // AND-OR source selection, gated by the clock enable
  always_comb begin
    if (clk_en) q_nxt = (d_ser & sel_shift) | (d_par & sel_load);
    else        q_nxt = q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/plsr_shift_reg.sv
module plsr_shift_reg #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_shift,
  input  logic             hold_en,
  input  logic             sin,
  input  logic [WIDTH-1:0] pdata,
  output logic             sout,
  output logic [WIDTH-1:0] state_q
);
  localparam int LAST = WIDTH - 1;

  logic             rst_sync_n;
  logic             clk_en;
  logic             sel_shift;
  logic             sel_load;
  logic [WIDTH-1:0] ser_src;
  logic [WIDTH-1:0] stage_q;

  plsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  plsr_ctrl u_ctrl (
    .hold_en    (hold_en),
    .mode_shift (mode_shift),
    .clk_en     (clk_en),
    .sel_shift  (sel_shift),
    .sel_load   (sel_load)
  );

  // the first stage takes sin, every later stage takes its upstream neighbour
  assign ser_src = {stage_q[LAST-1:0], sin};

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    plsr_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .clk_en    (clk_en),
      .sel_shift (sel_shift),
      .sel_load  (sel_load),
      .d_ser     (ser_src[i]),
      .d_par     (pdata[i]),
      .q         (stage_q[i])
    );
  end

  assign sout    = stage_q[LAST];
  assign state_q = stage_q;
endmodule

// File: rtl/plsr_shift_reg_chk.sv
module plsr_shift_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             mode_shift,
  input logic             hold_en,
  input logic             sin,
  input logic [WIDTH-1:0] pdata,
  input logic             sout,
  input logic [WIDTH-1:0] state_q
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !hold_en && !mode_shift) |=> state_q == $past(pdata));

  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !hold_en && mode_shift)
      |=> state_q == {$past(state_q[WIDTH-2:0]), $past(sin)});

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_en |=> $stable(state_q));

  p_release_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> state_q == '0);

  p_sout_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !hold_en && !mode_shift) |=> sout == $past(pdata[WIDTH-1]));
endmodule

bind plsr_shift_reg plsr_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .mode_shift (mode_shift),
  .hold_en    (hold_en),
  .sin        (sin),
  .pdata      (pdata),
  .sout       (sout),
  .state_q    (state_q)
);

// File: tb/plsr_shift_reg_test.sv
`timescale 1ns/1ps
module plsr_shift_reg_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_shift;
  logic         hold_en;
  logic         sin;
  logic [W-1:0] pdata;
  logic         sout;
  logic [W-1:0] state_q;

  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  bit    live   = 1'b0;
  string req    = "R1";

  // behavioural reference
  int unsigned m_val;
  int          since_rel;

  always #4 clk = ~clk;

  plsr_shift_reg #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .mode_shift(mode_shift), .hold_en(hold_en),
    .sin(sin), .pdata(pdata), .sout(sout), .state_q(state_q)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_val     = 0;
      since_rel = 0;
    end else if (since_rel < 2) begin
      since_rel = since_rel + 1;
      m_val     = 0;
    end else if (hold_en) begin
      m_val = m_val;
    end else if (mode_shift) begin
      m_val = ((m_val * 2) + (sin ? 1 : 0)) % (1 << W);
    end else begin
      m_val = int'(pdata);
    end
  end

  task automatic check(input string r, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", r, got, exp, $time);
    end
  endtask

  // per-cycle comparison with the model (R8 state, R1 serial output)
  always @(negedge clk) begin
    if (live) begin
      check({req, "/R8 state"}, state_q, W'(m_val));
      check({req, "/R1 sout"}, {{(W-1){1'b0}}, sout}, {{(W-1){1'b0}}, m_val[W-1]});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    logic [W-1:0] word;
    rst_n = 1'b0; mode_shift = 1'b0; hold_en = 1'b0; sin = 1'b0; pdata = 8'hFF;
    repeat (3) @(negedge clk);
    check("R5 reset state", state_q, '0);

    // R6: load request held across the release
    req = "R6";
    live = 1'b1;
    rst_n = 1'b1;
    @(negedge clk); check("R6 edge1 still clear", state_q, '0);
    @(negedge clk); check("R6 edge2 still clear", state_q, '0);
    @(negedge clk); check("R6 edge3 loads", state_q, 8'hFF);

    // R2 load, then R7 serial order
    req = "R2";
    pdata = 8'hA5;
    @(negedge clk); check("R2 load A5", state_q, 8'hA5);
    req = "R7";
    mode_shift = 1'b1;
    word = 8'hA5;
    for (int i = 0; i < W; i++) begin
      check("R7 serial order", {7'd0, sout}, {7'd0, word[W-1-i]});
      sin = i[0];
      @(negedge clk);
    end
    // R3: the serial bits now fill the register (0,1,0,1,... from stage 0 upward in age)
    req = "R3";
    check("R3 filled by sin", state_q, 8'b01010101);

    // R4: hold ignores load and shift
    req = "R4";
    hold_en = 1'b1; mode_shift = 1'b0; pdata = 8'h3C;
    @(negedge clk); check("R4 hold vs load", state_q, 8'b01010101);
    mode_shift = 1'b1; sin = 1'b1;
    @(negedge clk); check("R4 hold vs shift", state_q, 8'b01010101);
    hold_en = 1'b0;

    // pseudo-random mix
    req = "R3/R4/R2 mix";
    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mode_shift = lf[0] | lf[1];
      hold_en    = lf[2] & lf[3];
      sin        = lf[4];
      pdata      = lf[15:8];
      @(negedge clk);
    end

    // R5: clear in the middle of the low phase while shifting
    req = "R5";
    hold_en = 1'b0; mode_shift = 1'b0; pdata = 8'hC3;
    @(negedge clk);
    mode_shift = 1'b1; sin = 1'b1;
    #2 rst_n = 1'b0;
    #1 check("R5 async clear", state_q, '0);
    check("R5 async clear sout", {7'd0, sout}, 8'd0);
    @(negedge clk); check("R5 clear overrides", state_q, '0);
    rst_n = 1'b1;
    req = "R6";
    mode_shift = 1'b0; pdata = 8'h81;
    repeat (4) @(negedge clk);
    check("R6 after second release", state_q, 8'h81);
    live = 1'b0;
    finish_run();
  end
endmodule